// File: doc/BRIEF.md
# Link Power-State Request Handshake

This block is the link-layer controller that negotiates the move from the active interface into one of two reduced-power interface states: partial, which comes back quickly, or slumber, which saves more power but takes much longer to recover. Both ends of a link run the same controller, so one state machine acts as either initiator or responder.

As initiator, the controller takes a request pulse from the upper layer. It then places the matching request primitive on every slot the physical layer offers, until the far end answers with an accept or a reject, or until a programmable number of requests has gone unanswered. As responder, it sees a request primitive arrive and raises a decision request to the upper layer. Once the decision arrives, it sends a burst of accept or reject primitives. The burst length comes from a configuration field clamped to the range 4 to 16. Primitives cross the block edge as decoded strobes: a valid bit with a 3-bit type code. In both directions the code is 1 for partial-request, 2 for slumber-request, 3 for accept and 4 for reject. Any other code is an unrelated primitive.

States: `ST_IDLE`, `ST_INIT_REQ` (sending requests), `ST_RESP_WAIT` (awaiting the upper-layer decision), `ST_RESP_SEND` (sending the response burst), `ST_LP_PARTIAL` and `ST_LP_SLUMBER`. The transitions are as follows:
- IDLE→INIT_REQ on a local request.
- IDLE→RESP_WAIT on an incoming request.
- INIT_REQ→LP_x on accept.
- INIT_REQ→IDLE on reject or timeout.
- RESP_WAIT→RESP_SEND on a decision.
- RESP_SEND→LP_x after the last accept of the burst.
- RESP_SEND→IDLE after the last reject of the burst.
- LP_x→IDLE on wake.

Top module: `lpm_handshake`

## Requirements
- R1: After reset the block is idle: `tx_valid`=0, `ask_valid`=0, `pm_state`=0 (active), `rej_pulse`=0, `tmo_pulse`=0.
- R2: In INIT_REQ the block drives `tx_valid` only together with `tx_slot`, and on every such slot it sends code 1 for a partial request or code 2 for a slumber request.
- R3: When an accept (code 3) arrives in INIT_REQ, no request primitive is sent in that cycle or after it. From the next cycle `pm_state` shows the requested state: 1 for partial, 2 for slumber.
- R4: When a reject (code 4) arrives in INIT_REQ, `rej_pulse` is high for that one cycle and no request is sent. The block then returns to idle with `pm_state`=0.
- R5: If `cfg_timeout` requests have been sent with no response, `tmo_pulse` is high for one cycle. The block then returns to idle and sends no further requests.
- R6: A request primitive received in IDLE raises `ask_valid` in the next cycle, with `ask_slumber` set for code 2. `ask_valid` holds until `dec_valid`.
- R7: After the decision, the block sends exactly clamp(`cfg_burst_len`, 4, 16) response primitives: code 3 when `dec_accept`=1, otherwise code 4. It sends one on each `tx_slot`.
- R8: After the last primitive of an accept burst, `pm_state` shows the requested state. After the last primitive of a reject burst, the block is idle with `pm_state`=0.
- R9: An incoming request primitive is ignored in INIT_REQ, RESP_WAIT, RESP_SEND and the low-power states. `ask_valid` stays 0 and `pm_state` does not change.
- R10: In a low-power state, `wake` returns `pm_state` to 0 in the next cycle.
- R11: When a local request and an incoming request arrive in the same IDLE cycle, the local request wins. The block sends its own requests and never raises `ask_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upper layer asks to enter low power |
| req_slumber | input | 1 | Target of that request: 1 slumber, 0 partial |
| wake | input | 1 | Leave the low-power state |
| dec_valid | input | 1 | Upper-layer decision on a received request |
| dec_accept | input | 1 | Decision: 1 accept, 0 reject |
| cfg_burst_len | input | LEN_W | Response burst length, clamped to 4..16 |
| cfg_timeout | input | TMO_W | Unanswered requests tolerated before giving up |
| rx_valid | input | 1 | Received primitive strobe |
| rx_prim | input | 3 | Received primitive code |
| tx_slot | input | 1 | Physical layer can take a primitive this cycle |
| tx_valid | output | 1 | Primitive offered in this slot |
| tx_prim | output | 3 | Offered primitive code |
| ask_valid | output | 1 | Decision needed for a received request |
| ask_slumber | output | 1 | The received request targets slumber |
| pm_state | output | 2 | 0 active, 1 partial, 2 slumber |
| rej_pulse | output | 1 | Own request was rejected |
| tmo_pulse | output | 1 | Own request abandoned for lack of response |

## Verification
The assertions assume that `tx_slot` and the received strobes are single-cycle and synchronous to `clk`, and that the upper layer gives a decision only while `ask_valid` is high. They also assume a nonzero `cfg_timeout`. The stimulus drives every input shortly after a rising edge and holds it for whole cycles. It raises `dec_valid` only after checking `ask_valid`, and it keeps the timeout at 3 or 100 so that responses always come within the window, except in the timeout case itself.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        PRIM_OTHER = 3'd0,
        PRIM_REQ_P = 3'd1,
        PRIM_REQ_S = 3'd2,
        PRIM_ACK   = 3'd3,
        PRIM_NAK   = 3'd4
    } prim_e;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_SLUMBER = 2'd2
    } pm_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_REQ,
        ST_RESP_WAIT,
        ST_RESP_SEND,
        ST_LP_PARTIAL,
        ST_LP_SLUMBER
    } state_e;

    localparam int unsigned BURST_MIN = 4;
    localparam int unsigned BURST_MAX = 16;

endpackage

// File: rtl/lpm_slot_timer.sv
// Counts request primitives actually sent; flags when the limit is reached.
module lpm_slot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (tick && cnt_q != SAT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/lpm_burst_ctr.sv
// Loads the clamped burst length and counts response primitives down.
module lpm_burst_ctr
    import lpm_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    output logic             last
);
    localparam int CNT_W = $clog2(BURST_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        if (32'(len) < BURST_MIN)
            load_val = CNT_W'(BURST_MIN);
        else if (32'(len) > BURST_MAX)
            load_val = CNT_W'(BURST_MAX);
        else
            load_val = CNT_W'(len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lpm_handshake.sv
module lpm_handshake
    import lpm_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_slumber,
    input  logic             wake,
    input  logic             dec_valid,
    input  logic             dec_accept,
    input  logic [LEN_W-1:0] cfg_burst_len,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             rx_valid,
    input  logic [2:0]       rx_prim,
    input  logic             tx_slot,
    output logic             tx_valid,
    output logic [2:0]       tx_prim,
    output logic             ask_valid,
    output logic             ask_slumber,
    output logic [1:0]       pm_state,
    output logic             rej_pulse,
    output logic             tmo_pulse
);
    state_e state_q, state_d;
    logic   kind_q;      // 1 = slumber target
    logic   accept_q;    // responder decision
    logic   rx_req, rx_ack, rx_nak, rx_resp;
    logic   expired, burst_last;
    logic   in_init;

    assign rx_req  = rx_valid && (rx_prim == PRIM_REQ_P || rx_prim == PRIM_REQ_S);
    assign rx_ack  = rx_valid && (rx_prim == PRIM_ACK);
    assign rx_nak  = rx_valid && (rx_prim == PRIM_NAK);
    assign rx_resp = rx_ack || rx_nak;
    assign in_init = (state_q == ST_INIT_REQ);

    lpm_slot_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_init),
        .tick    (in_init && tx_valid),
        .limit   (cfg_timeout),
        .expired (expired)
    );

    lpm_burst_ctr #(.LEN_W(LEN_W)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_RESP_WAIT && dec_valid),
        .len   (cfg_burst_len),
        .tick  (state_q == ST_RESP_SEND && tx_valid),
        .last  (burst_last)
    );

    // State register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (req_valid)
                    kind_q <= req_slumber;
                else if (rx_req)
                    kind_q <= (rx_prim == PRIM_REQ_S);
            end
            if (state_q == ST_RESP_WAIT && dec_valid)
                accept_q <= dec_accept;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)       state_d = ST_INIT_REQ;
                else if (rx_req)     state_d = ST_RESP_WAIT;
            end
            ST_INIT_REQ: begin
                if (rx_ack)          state_d = kind_q ? ST_LP_SLUMBER : ST_LP_PARTIAL;
                else if (rx_nak)     state_d = ST_IDLE;
                else if (expired)    state_d = ST_IDLE;
            end
            ST_RESP_WAIT: begin
                if (dec_valid)       state_d = ST_RESP_SEND;
            end
            ST_RESP_SEND: begin
                if (tx_slot && burst_last)
                    state_d = accept_q ? (kind_q ? ST_LP_SLUMBER : ST_LP_PARTIAL)
                                       : ST_IDLE;
            end
            ST_LP_PARTIAL, ST_LP_SLUMBER: begin
                if (wake)            state_d = ST_IDLE;
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid    = 1'b0;
        tx_prim     = PRIM_OTHER;
        ask_valid   = 1'b0;
        ask_slumber = kind_q;
        pm_state    = PM_ACTIVE;
        rej_pulse   = 1'b0;
        tmo_pulse   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT_REQ: begin
                tx_valid  = tx_slot && !rx_resp && !expired;
                tx_prim   = kind_q ? PRIM_REQ_S : PRIM_REQ_P;
                rej_pulse = rx_nak;
                tmo_pulse = expired && !rx_resp;
            end
            ST_RESP_WAIT:  ask_valid = 1'b1;
            ST_RESP_SEND: begin
                tx_valid = tx_slot;
                tx_prim  = accept_q ? PRIM_ACK : PRIM_NAK;
            end
            ST_LP_PARTIAL: pm_state = PM_PARTIAL;
            ST_LP_SLUMBER: pm_state = PM_SLUMBER;
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_handshake_chk.sv
module lpm_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_slot,
    input logic       tx_valid,
    input logic [2:0] tx_prim,
    input logic       rx_valid,
    input logic [2:0] rx_prim,
    input logic       ask_valid,
    input logic [1:0] pm_state,
    input logic       rej_pulse,
    input logic       tmo_pulse
);
    logic [5:0] resp_run;
    logic       tx_resp;

    assign tx_resp = tx_valid && (tx_prim == 3'd3 || tx_prim == 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_run <= '0;
        else if (ask_valid)
            resp_run <= '0;
        else if (tx_resp && resp_run != 6'h3f)
            resp_run <= resp_run + 1'b1;
    end

    AST_TX_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_slot); // R2
    AST_NO_REQ_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_prim == 3'd3 || rx_prim == 3'd4))
            |-> !(tx_valid && (tx_prim == 3'd1 || tx_prim == 3'd2))); // R3
    AST_REJ_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rej_pulse |=> (pm_state == 2'd0)); // R4
    AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> (pm_state == 2'd0 && !ask_valid)); // R5
    AST_ASK_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        ask_valid |-> !tx_valid); // R6
    AST_BURST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_run <= 6'd16); // R7
    AST_BURST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ask_valid) && resp_run != 6'd0) |-> (resp_run >= 6'd4)); // R7
    AST_LP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state != 2'd0) |-> (!tx_valid && !ask_valid)); // R9
endmodule

bind lpm_handshake lpm_handshake_chk u_chk (.*);

// File: tb/tb_lpm_handshake.sv
`timescale 1ns/1ps
module tb_lpm_handshake;
    localparam int LEN_W = 5;
    localparam int TMO_W = 16;
    localparam logic [2:0] P_REQ_P = 3'd1, P_REQ_S = 3'd2, P_ACK = 3'd3, P_NAK = 3'd4;

    logic clk = 1'b0;
    logic rst_n, req_valid, req_slumber, wake, dec_valid, dec_accept;
    logic [LEN_W-1:0] cfg_burst_len;
    logic [TMO_W-1:0] cfg_timeout;
    logic rx_valid, tx_slot;
    logic [2:0] rx_prim;
    logic tx_valid, ask_valid, ask_slumber, rej_pulse, tmo_pulse;
    logic [2:0] tx_prim;
    logic [1:0] pm_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [2:0] exp_q[$];
    logic [2:0] mon_e;

    always #2.5 clk = ~clk;

    lpm_handshake #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slumber(req_slumber),
        .wake(wake), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .cfg_burst_len(cfg_burst_len), .cfg_timeout(cfg_timeout),
        .rx_valid(rx_valid), .rx_prim(rx_prim), .tx_slot(tx_slot),
        .tx_valid(tx_valid), .tx_prim(tx_prim), .ask_valid(ask_valid),
        .ask_slumber(ask_slumber), .pm_state(pm_state),
        .rej_pulse(rej_pulse), .tmo_pulse(tmo_pulse)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] p, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(p);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: every offered primitive must match the next expected one
    always @(negedge clk) begin
        if (rst_n === 1'b1 && tx_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2/R7 unexpected primitive actual=%0d expected=none", tx_prim);
            end else begin
                mon_e = exp_q.pop_front();
                chk(tx_prim == mon_e, "R2/R7 primitive stream", int'(tx_prim), int'(mon_e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_slumber = 1'b0; wake = 1'b0;
        dec_valid = 1'b0; dec_accept = 1'b0; rx_valid = 1'b0; rx_prim = 3'd0;
        tx_slot = 1'b1; cfg_burst_len = 5'd5; cfg_timeout = 16'd100;
        repeat (3) step();
        rst_n = 1'b1;
        look();
        // R1 reset state
        chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        chk(ask_valid == 1'b0, "R1 ask_valid", ask_valid, 0);
        chk(pm_state == 2'd0, "R1 pm_state", pm_state, 0);
        chk(rej_pulse == 1'b0 && tmo_pulse == 1'b0, "R1 pulses", rej_pulse | tmo_pulse, 0);

        // R2/R3: partial request accepted after three requests; R9 during INIT
        push(P_REQ_P, 3);
        step(); req_valid = 1'b1; req_slumber = 1'b0;
        step(); req_valid = 1'b0;                 // c1
        step(); rx_valid = 1'b1; rx_prim = P_REQ_S; // c2
        step(); rx_valid = 1'b0;                  // c3
        look(); chk(ask_valid == 1'b0, "R9 request ignored in INIT", ask_valid, 0);
        step(); rx_valid = 1'b1; rx_prim = P_ACK; // c4
        look(); chk(tx_valid == 1'b0, "R3 no request on accept", tx_valid, 0);
        step(); rx_valid = 1'b0;
        look(); chk(pm_state == 2'd1, "R3 partial entered", pm_state, 1);
        step(); wake = 1'b1;
        step(); wake = 1'b0;
        look(); chk(pm_state == 2'd0, "R10 wake to active", pm_state, 0);

        // R4: slumber request rejected
        push(P_REQ_S, 2);
        step(); req_valid = 1'b1; req_slumber = 1'b1;
        step(); req_valid = 1'b0;                 // c1
        step();                                   // c2
        step(); rx_valid = 1'b1; rx_prim = P_NAK; // c3
        look();
        chk(rej_pulse == 1'b1, "R4 reject pulse", rej_pulse, 1);
        chk(tx_valid == 1'b0, "R4 no request on reject", tx_valid, 0);
        step(); rx_valid = 1'b0;
        look();
        chk(pm_state == 2'd0, "R4 back to active", pm_state, 0);
        chk(rej_pulse == 1'b0, "R4 pulse one cycle", rej_pulse, 0);

        // R5: timeout after three unanswered requests
        cfg_timeout = 16'd3;
        push(P_REQ_P, 3);
        step(); req_valid = 1'b1; req_slumber = 1'b0;
        step(); req_valid = 1'b0;                 // c1
        step(); step(); step();                   // c4
        look(); chk(tmo_pulse == 1'b1, "R5 timeout pulse", tmo_pulse, 1);
        step();
        look();
        chk(tmo_pulse == 1'b0, "R5 pulse one cycle", tmo_pulse, 0);
        chk(tx_valid == 1'b0, "R5 requests stopped", tx_valid, 0);
        cfg_timeout = 16'd100;

        // R6/R7/R8: responder accepts slumber, burst of 6
        cfg_burst_len = 5'd6;
        step(); rx_valid = 1'b1; rx_prim = P_REQ_S;
        step(); rx_valid = 1'b0;
        look();
        chk(ask_valid == 1'b1, "R6 ask raised", ask_valid, 1);
        chk(ask_slumber == 1'b1, "R6 ask kind slumber", ask_slumber, 1);
        step(); step();
        look(); chk(ask_valid == 1'b1, "R6 ask held", ask_valid, 1);
        push(P_ACK, 6);
        dec_valid = 1'b1; dec_accept = 1'b1;
        step(); dec_valid = 1'b0;
        repeat (6) step();
        look(); chk(pm_state == 2'd2, "R8 slumber after accept burst", pm_state, 2);
        rx_valid = 1'b1; rx_prim = P_REQ_P;
        step(); rx_valid = 1'b0;
        look();
        chk(ask_valid == 1'b0, "R9 request ignored in low power", ask_valid, 0);
        chk(pm_state == 2'd2, "R9 state kept", pm_state, 2);
        wake = 1'b1;
        step(); wake = 1'b0;

        // R7/R8: reject burst, length 2 clamped to 4, gapped slots
        cfg_burst_len = 5'd2;
        step(); rx_valid = 1'b1; rx_prim = P_REQ_P;
        step(); rx_valid = 1'b0;
        look(); chk(ask_slumber == 1'b0, "R6 ask kind partial", ask_slumber, 0);
        push(P_NAK, 4);
        dec_valid = 1'b1; dec_accept = 1'b0;
        step(); dec_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tx_slot = (i % 2 == 0);
            step();
        end
        tx_slot = 1'b1;
        look();
        chk(pm_state == 2'd0, "R8 active after reject burst", pm_state, 0);
        chk(tx_valid == 1'b0, "R7 burst ended at four", tx_valid, 0);
        chk(ask_valid == 1'b0, "R8 idle after reject", ask_valid, 0);

        // R7: length 20 clamped to 16, partial accepted
        cfg_burst_len = 5'd20;
        step(); rx_valid = 1'b1; rx_prim = P_REQ_P;
        step(); rx_valid = 1'b0;
        push(P_ACK, 16);
        dec_valid = 1'b1; dec_accept = 1'b1;
        step(); dec_valid = 1'b0;
        repeat (15) step();
        look(); chk(pm_state == 2'd0, "R7 burst still running at 16th", pm_state, 0);
        step();
        look(); chk(pm_state == 2'd1, "R7 partial after 16", pm_state, 1);
        wake = 1'b1;
        step(); wake = 1'b0;

        // R11: local request beats incoming one in the same cycle
        push(P_REQ_P, 1);
        step(); req_valid = 1'b1; req_slumber = 1'b0; rx_valid = 1'b1; rx_prim = P_REQ_S;
        step(); req_valid = 1'b0; rx_valid = 1'b0;
        look(); chk(ask_valid == 1'b0, "R11 no ask on collision", ask_valid, 0);
        step(); rx_valid = 1'b1; rx_prim = P_ACK;
        step(); rx_valid = 1'b0;
        look(); chk(pm_state == 2'd1, "R11 own partial won", pm_state, 1);
        wake = 1'b1;
        step(); wake = 1'b0;

        repeat (3) step();
        chk(exp_q.size() == 0, "R2/R7 all expected primitives seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule